// File: doc/BRIEF.md
# Consumer IR Pulse Receiver

This block is the front end of a remote-control infrared receiver. It samples a demodulated IR line on a slow sample tick derived from the system clock, with an optional polarity inversion. It filters out short glitches and measures how long the line stays at each level. Each measured run leaves the block as one byte for an external FIFO: the level in the top bit and the length in sample ticks below it. Runs too long for one byte are split into several bytes.

The receiver rests in an idle state until the first accepted level change. It then stays in a receiving state until the line holds one level for a programmable idle time. At that point it returns to idle, raises a sticky end-of-command flag, and drives an interrupt if that interrupt is enabled. Software clears the sticky flags with one-cycle clear pulses. A write that meets a full FIFO is dropped and sets a sticky overrun flag. Carrier demodulation, the register bus and the FIFO storage sit outside this block.

Top module: `cir_pulse_rx`

## Requirements
- R1: The sample select is `{selHi, selLo}` (0 to 7). One sample is taken every 2^(select+6) clocks. Counting starts at the first clock edge after reset release, so the first sample falls on edge number 2^(select+6).
- R2: The line level is `rawIn XOR invertRx`. With `invertRx` = 1, a low `rawIn` is level 1. Bit 7 of every code holds the line level of the run it describes.
- R3: A level change is accepted only after the new level has been seen on N consecutive samples, where N is `noiseThr`, and `noiseThr` = 0 behaves as 1. A shorter excursion is dropped, and its samples count toward the run it interrupted.
- R4: After reset the receiver is idle (`rxBusy` = 0) and writes no codes. The first accepted level change moves it to receiving (`rxBusy` = 1) without writing a code.
- R5: While receiving, each accepted level change writes one code for the run just finished. Bits 6:0 of that code hold the run's true length in samples.
- R6: When the current run reaches 127 samples, a code with length 127 is written at once and counting restarts. The remainder is written later.
- R7: While receiving, if no level change is accepted for max(`idleThr`,1)×128 samples, the receiver goes idle, sets `endFlag`, and discards the unfinished run.
- R8: `irqOut` is high exactly while `endFlag` and `endIntEn` are both high.
- R9: `endFlag` and `ovfFlag` stay set until a one-cycle `clrEnd` or `clrOvf` pulse clears them. When a set and a clear fall in the same cycle, the set wins.
- R10: When `fifoFull` is high in the cycle a code is due, `fifoWrite` stays low, the code is lost, and `ovfFlag` is set.
- R11: Out of reset, `fifoWrite`, `rxBusy`, `endFlag`, `ovfFlag` and `irqOut` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| rawIn | input | 1 | Demodulated IR line, asynchronous |
| selLo | input | 2 | Low bits of the sample-rate select |
| selHi | input | 1 | High bit of the sample-rate select |
| invertRx | input | 1 | 1 inverts the line before sampling |
| noiseThr | input | 6 | Samples a new level must persist before it is accepted |
| idleThr | input | 8 | Idle time in units of 128 samples |
| endIntEn | input | 1 | Enables the end-of-command interrupt |
| clrEnd | input | 1 | Clear pulse for endFlag |
| clrOvf | input | 1 | Clear pulse for ovfFlag |
| fifoFull | input | 1 | Downstream FIFO cannot take a byte |
| fifoWrite | output | 1 | One-cycle write strobe for fifoData |
| fifoData | output | 8 | Run code: level in bit 7, length in bits 6:0 |
| rxBusy | output | 1 | Receiver is in the receiving state |
| endFlag | output | 1 | Sticky end-of-command flag |
| ovfFlag | output | 1 | Sticky dropped-code flag |
| irqOut | output | 1 | End-of-command interrupt |

## Verification
A wrong run or candidate count shows up at the ports as a code whose length is off. The error appears when the next level change is accepted, or sooner as an early or missing 127-length chunk. A state register stuck in receiving shows up within one idle window, as `endFlag` failing to rise or chunks continuing. A state stuck in idle shows up at the first pulse, as missing codes. A lost glitch filter shows up as extra short codes right after a brief excursion. An overrun that is wrongly gated shows up in the same cycle, as a write strobe while `fifoFull` is high.

// File: rtl/cir_pkg.sv
package cir_pkg;

  // Receiver mode
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RECV = 1'b1
  } rxState_e;

  // Strobes from control to datapath, valid for one clock
  typedef struct packed {
    logic tick;     // sample instant
    logic accept;   // a level change is accepted on this sample
    logic advance;  // receiving, no change, no timeout: count on
    logic timeout;  // idle window expired
    logic emit;     // a code leaves on the next cycle
  } ctrlStrobe_t;

  // Conditions reported by the datapath to control
  typedef struct packed {
    logic candDone; // new level has persisted long enough
    logic runSat;   // run counter at its last value before saturating
    logic idleDone; // idle window ends on this sample
  } dpStatus_t;

endpackage

// File: rtl/cir_rx_ctrl.sv
module cir_rx_ctrl
  import cir_pkg::*;
#(
  parameter int PRE_BASE = 6,
  parameter int SEL_W    = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [SEL_W-1:0] sel,
  input  dpStatus_t        status,
  output ctrlStrobe_t      stb,
  output logic             busy
);

  localparam int CNT_W = PRE_BASE + (1 << SEL_W) - 1;

  logic [CNT_W-1:0] preCnt;
  logic [CNT_W-1:0] tickMask;
  rxState_e         state;
  rxState_e         stateNext;
  logic             tick;
  logic             recv;

  // Free-running prescaler; sample when the selected low bits are all ones
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) preCnt <= '0;
    else       preCnt <= preCnt + CNT_W'(1);
  end

  always_comb begin
    tickMask = {CNT_W{1'b1}} >> (~sel);
    tick     = (preCnt & tickMask) == tickMask;
  end

  always_comb begin
    recv        = (state == ST_RECV);
    stb.tick    = tick;
    stb.accept  = tick && status.candDone;
    stb.timeout = tick && recv && !stb.accept && status.idleDone;
    stb.advance = tick && recv && !stb.accept && !stb.timeout;
    stb.emit    = (stb.accept && recv) || (stb.advance && status.runSat);
  end

  always_comb begin
    stateNext = state;
    if (stb.accept)       stateNext = ST_RECV;
    else if (stb.timeout) stateNext = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign busy = recv;

endmodule

// File: rtl/cir_rx_dpath.sv
module cir_rx_dpath
  import cir_pkg::*;
#(
  parameter int NOISE_W     = 6,
  parameter int IDLE_W      = 8,
  parameter int IDLE_SHIFT  = 7,
  parameter int RUN_W       = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               rawIn,
  input  logic               invertRx,
  input  logic [NOISE_W-1:0] noiseThr,
  input  logic [IDLE_W-1:0]  idleThr,
  input  logic               fifoFull,
  input  logic               clrEnd,
  input  logic               clrOvf,
  input  ctrlStrobe_t        stb,
  output dpStatus_t          status,
  output logic               fifoWrite,
  output logic [RUN_W:0]     fifoData,
  output logic               endFlag,
  output logic               ovfFlag
);

  localparam int IDLE_CNT_W = IDLE_W + IDLE_SHIFT;
  localparam int RUN_MAX    = (1 << RUN_W) - 1;

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   sample;
  logic                   stableLvl;
  logic                   diff;
  logic [NOISE_W-1:0]     candCnt;
  logic [NOISE_W:0]       candNext;
  logic [NOISE_W:0]       effNoise;
  logic [RUN_W-1:0]       runCnt;
  logic [RUN_W-1:0]       runNext;
  logic [IDLE_CNT_W-1:0]  idleCnt;
  logic [IDLE_CNT_W:0]    idleNext;
  logic [IDLE_W-1:0]      idleBase;
  logic [IDLE_CNT_W:0]    effIdle;
  logic [RUN_W:0]         codeQ;
  logic                   wrPend;

  // Input synchronizer, depth picked by parameter
  generate
    if (SYNC_STAGES == 1) begin : gSyncOne
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= rawIn;
      end
    end else begin : gSyncChain
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= {syncQ[SYNC_STAGES-2:0], rawIn};
      end
    end
  endgenerate

  always_comb begin
    sample   = syncQ[SYNC_STAGES-1] ^ invertRx;
    diff     = sample != stableLvl;
    candNext = {1'b0, candCnt} + (NOISE_W+1)'(1);
    effNoise = (noiseThr == '0) ? (NOISE_W+1)'(1) : {1'b0, noiseThr};
    runNext  = runCnt + RUN_W'(1);
    idleNext = {1'b0, idleCnt} + (IDLE_CNT_W+1)'(1);
    idleBase = (idleThr == '0) ? IDLE_W'(1) : idleThr;
    effIdle  = {1'b0, idleBase, {IDLE_SHIFT{1'b0}}};

    status.candDone = diff && (candNext >= effNoise);
    status.runSat   = (runCnt == RUN_W'(RUN_MAX - 1));
    status.idleDone = (idleNext >= effIdle);
  end

  // Accepted level and pending-change counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stableLvl <= 1'b0;
      candCnt   <= '0;
    end else if (stb.tick) begin
      if (stb.accept) stableLvl <= sample;
      if (diff && !status.candDone) candCnt <= candNext[NOISE_W-1:0];
      else                          candCnt <= '0;
    end
  end

  // Run length and idle counters
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runCnt  <= '0;
      idleCnt <= '0;
    end else if (stb.accept || stb.timeout) begin
      runCnt  <= '0;
      idleCnt <= '0;
    end else if (stb.advance) begin
      runCnt  <= status.runSat ? '0 : runNext;
      idleCnt <= idleNext[IDLE_CNT_W-1:0];
    end
  end

  // Code register towards the FIFO
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      codeQ  <= '0;
      wrPend <= 1'b0;
    end else begin
      wrPend <= stb.emit;
      if (stb.emit) codeQ <= {stableLvl, runNext};
    end
  end

  assign fifoWrite = wrPend && !fifoFull;
  assign fifoData  = codeQ;

  // Sticky flags, set has priority over clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      endFlag <= 1'b0;
      ovfFlag <= 1'b0;
    end else begin
      if (stb.timeout)         endFlag <= 1'b1;
      else if (clrEnd)         endFlag <= 1'b0;
      if (wrPend && fifoFull)  ovfFlag <= 1'b1;
      else if (clrOvf)         ovfFlag <= 1'b0;
    end
  end

endmodule

// File: rtl/cir_pulse_rx.sv
module cir_pulse_rx
  import cir_pkg::*;
#(
  parameter int PRE_BASE    = 6,
  parameter int SEL_LO_W    = 2,
  parameter int NOISE_W     = 6,
  parameter int IDLE_W      = 8,
  parameter int IDLE_SHIFT  = 7,
  parameter int RUN_W       = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                rawIn,
  input  logic [SEL_LO_W-1:0] selLo,
  input  logic                selHi,
  input  logic                invertRx,
  input  logic [NOISE_W-1:0]  noiseThr,
  input  logic [IDLE_W-1:0]   idleThr,
  input  logic                endIntEn,
  input  logic                clrEnd,
  input  logic                clrOvf,
  input  logic                fifoFull,
  output logic                fifoWrite,
  output logic [RUN_W:0]      fifoData,
  output logic                rxBusy,
  output logic                endFlag,
  output logic                ovfFlag,
  output logic                irqOut
);

  localparam int SEL_W = SEL_LO_W + 1;

  ctrlStrobe_t stb;
  dpStatus_t   status;

  cir_rx_ctrl #(
    .PRE_BASE (PRE_BASE),
    .SEL_W    (SEL_W)
  ) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .sel    ({selHi, selLo}),
    .status (status),
    .stb    (stb),
    .busy   (rxBusy)
  );

  cir_rx_dpath #(
    .NOISE_W     (NOISE_W),
    .IDLE_W      (IDLE_W),
    .IDLE_SHIFT  (IDLE_SHIFT),
    .RUN_W       (RUN_W),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .rawIn     (rawIn),
    .invertRx  (invertRx),
    .noiseThr  (noiseThr),
    .idleThr   (idleThr),
    .fifoFull  (fifoFull),
    .clrEnd    (clrEnd),
    .clrOvf    (clrOvf),
    .stb       (stb),
    .status    (status),
    .fifoWrite (fifoWrite),
    .fifoData  (fifoData),
    .endFlag   (endFlag),
    .ovfFlag   (ovfFlag)
  );

  assign irqOut = endFlag && endIntEn;

endmodule

// File: rtl/cir_pulse_rx_chk.sv
module cir_pulse_rx_chk #(
  parameter int RUN_W = 7
) (
  input logic           clk,
  input logic           rstN,
  input logic           fifoFull,
  input logic           fifoWrite,
  input logic [RUN_W:0] fifoData,
  input logic           rxBusy,
  input logic           endFlag,
  input logic           ovfFlag,
  input logic           clrEnd,
  input logic           clrOvf
);

  // R10: a full FIFO never sees a write
  a_r10_no_write_when_full: assert property (@(posedge clk) disable iff (!rstN)
    fifoWrite |-> !fifoFull);

  // R5: every code carries a nonzero length
  a_r5_nonzero_length: assert property (@(posedge clk) disable iff (!rstN)
    fifoWrite |-> (fifoData[RUN_W-1:0] != '0));

  // R4: codes come only from the receiving state
  a_r4_write_from_receive: assert property (@(posedge clk) disable iff (!rstN)
    fifoWrite |-> $past(rxBusy));

  // R7: end of command marks the step from receiving to idle
  a_r7_end_leaves_receive: assert property (@(posedge clk) disable iff (!rstN)
    $rose(endFlag) |-> (!rxBusy && $past(rxBusy)));

  // R9: flags hold until cleared
  a_r9_end_sticky: assert property (@(posedge clk) disable iff (!rstN)
    ($past(endFlag) && !$past(clrEnd)) |-> endFlag);

  a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (!rstN)
    ($past(ovfFlag) && !$past(clrOvf)) |-> ovfFlag);

endmodule

bind cir_pulse_rx cir_pulse_rx_chk #(.RUN_W(RUN_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .fifoFull  (fifoFull),
  .fifoWrite (fifoWrite),
  .fifoData  (fifoData),
  .rxBusy    (rxBusy),
  .endFlag   (endFlag),
  .ovfFlag   (ovfFlag),
  .clrEnd    (clrEnd),
  .clrOvf    (clrOvf)
);

// File: tb/cir_pulse_rx_tb.sv
`timescale 1ns/1ps
module cir_pulse_rx_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       rawIn = 1'b1;
  logic [1:0] selLo = 2'd0;
  logic       selHi = 1'b0;
  logic       invertRx = 1'b1;
  logic [5:0] noiseThr = 6'd3;
  logic [7:0] idleThr = 8'd1;
  logic       endIntEn = 1'b1;
  logic       clrEnd = 1'b0;
  logic       clrOvf = 1'b0;
  logic       fifoFull = 1'b0;
  logic       fifoWrite;
  logic [7:0] fifoData;
  logic       rxBusy;
  logic       endFlag;
  logic       ovfFlag;
  logic       irqOut;

  int errors = 0;
  int checks = 0;
  int bcnt;
  int period = 64;
  logic [7:0] got[$];
  logic [7:0] expq[$];

  always #2 clk = ~clk;

  cir_pulse_rx u_dut (
    .clk(clk), .rstN(rstN), .rawIn(rawIn), .selLo(selLo), .selHi(selHi),
    .invertRx(invertRx), .noiseThr(noiseThr), .idleThr(idleThr),
    .endIntEn(endIntEn), .clrEnd(clrEnd), .clrOvf(clrOvf), .fifoFull(fifoFull),
    .fifoWrite(fifoWrite), .fifoData(fifoData), .rxBusy(rxBusy),
    .endFlag(endFlag), .ovfFlag(ovfFlag), .irqOut(irqOut)
  );

  // Clock edges since reset release (R1 timing model)
  always @(posedge clk or negedge rstN) begin
    if (!rstN) bcnt <= 0;
    else       bcnt <= bcnt + 1;
  end

  // Collect written codes
  always @(negedge clk) begin
    if (rstN && fifoWrite) got.push_back(fifoData);
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic compare(input string req);
    chk({req, " code count"}, got.size(), expq.size());
    for (int i = 0; i < got.size() && i < expq.size(); i++)
      chk({req, " code"}, int'(got[i]), int'(expq[i]));
  endtask

  task automatic align();
    period = 64 << {selHi, selLo};
    @(negedge clk);
    while ((bcnt % period) != period / 2) @(negedge clk);
  endtask

  task automatic seg(input logic lvl, input int ticks);
    rawIn = lvl ^ invertRx;
    repeat (ticks * period) @(negedge clk);
  endtask

  task automatic fresh();
    got.delete();
    expq.delete();
  endtask

  task automatic pulseClrEnd();
    clrEnd = 1'b1; @(negedge clk); clrEnd = 1'b0; @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R11 fifoWrite", fifoWrite, 0);
    chk("R11 rxBusy", rxBusy, 0);
    chk("R11 endFlag", endFlag, 0);
    chk("R11 ovfFlag", ovfFlag, 0);
    chk("R11 irqOut", irqOut, 0);
  endtask

  task automatic t_basic();
    fresh(); align();
    seg(0, 20);
    chk("R4 idle before pulse", rxBusy, 0);
    seg(1, 10);
    chk("R4 receiving after pulse", rxBusy, 1);
    seg(0, 5); seg(1, 8); seg(0, 140);
    expq = '{8'h8A, 8'h05, 8'h88, 8'h7F};
    compare("R5 R2 basic runs");
    chk("R7 endFlag", endFlag, 1);
    chk("R7 back to idle", rxBusy, 0);
    chk("R8 irq on", irqOut, 1);
    pulseClrEnd();
    chk("R9 endFlag cleared", endFlag, 0);
    chk("R8 irq off after clear", irqOut, 0);
  endtask

  task automatic t_glitch();
    fresh(); align();
    seg(1, 2); seg(0, 10);
    chk("R3 idle glitch ignored busy", rxBusy, 0);
    chk("R3 idle glitch no code", got.size(), 0);
    seg(1, 10); seg(0, 2); seg(1, 10); seg(0, 140);
    seg(1, 6); seg(0, 3); seg(1, 4); seg(0, 140);
    expq = '{8'h96, 8'h7F, 8'h86, 8'h03, 8'h84, 8'h7F};
    compare("R3 glitch absorbed, threshold pulse kept");
    pulseClrEnd();
  endtask

  task automatic t_long();
    fresh(); idleThr = 8'd2; align();
    seg(1, 250);
    chk("R7 no timeout before window", rxBusy, 1);
    seg(0, 250);
    chk("R7 endFlag not yet", endFlag, 0);
    seg(0, 15);
    chk("R7 endFlag after window", endFlag, 1);
    expq = '{8'hFF, 8'hFB, 8'h7F, 8'h7F};
    compare("R6 chunked long runs");
    idleThr = 8'd1;
    pulseClrEnd();
  endtask

  task automatic t_intdis();
    fresh(); endIntEn = 1'b0; align();
    seg(1, 5); seg(0, 140);
    chk("R8 flag set", endFlag, 1);
    chk("R8 irq masked", irqOut, 0);
    endIntEn = 1'b1; @(negedge clk);
    chk("R8 irq when enabled", irqOut, 1);
    expq = '{8'h85, 8'h7F};
    compare("R5 short pulse");
    pulseClrEnd();
  endtask

  task automatic t_ovf();
    fresh(); fifoFull = 1'b1; align();
    seg(1, 10); seg(0, 140);
    chk("R10 no writes when full", got.size(), 0);
    chk("R10 ovfFlag set", ovfFlag, 1);
    fifoFull = 1'b0;
    clrOvf = 1'b1; @(negedge clk); clrOvf = 1'b0; @(negedge clk);
    chk("R9 ovfFlag cleared", ovfFlag, 0);
    pulseClrEnd();
  endtask

  task automatic t_polarity();
    fresh();
    @(negedge clk); invertRx = 1'b0; rawIn = 1'b0;
    align();
    seg(1, 9); seg(0, 140);
    expq = '{8'h89, 8'h7F};
    compare("R2 non-inverted line");
    @(negedge clk); invertRx = 1'b1; rawIn = 1'b1;
    pulseClrEnd();
  endtask

  task automatic t_sel();
    fresh(); selLo = 2'd1; align();
    seg(1, 10); seg(0, 140);
    expq = '{8'h8A, 8'h7F};
    compare("R1 select 1");
    pulseClrEnd();
    fresh(); selLo = 2'd0; selHi = 1'b1; align();
    seg(1, 3); seg(0, 3);
    expq = '{8'h83};
    compare("R1 select 4 via high bit");
    selHi = 1'b0; align();
    seg(0, 140);
    chk("R1 return to idle", rxBusy, 0);
    pulseClrEnd();
  endtask

  task automatic t_noise0();
    fresh(); noiseThr = 6'd0; align();
    seg(1, 1); seg(0, 4); seg(1, 2); seg(0, 140);
    expq = '{8'h81, 8'h04, 8'h82, 8'h7F};
    compare("R3 zero threshold acts as one");
    noiseThr = 6'd3;
    pulseClrEnd();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_glitch();
    t_long();
    t_intdis();
    t_ovf();
    t_polarity();
    t_sel();
    t_noise0();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule